// File: doc/BRIEF.md
# Gated Clock Channel Divider

This block sits behind one PLL output and produces a slower clock for a single downstream consumer. It counts cycles of the fast source clock and drives a registered square wave whose period is a programmable number of source cycles. That number is an 8-bit divide field scaled by a fixed post-divider chosen when the block is instantiated. The output is a flop, so it never glitches and is safe to use as a clock.

Two control words gate the channel. The first word is local to the channel and supplies the divide field and a disable flag. The second is a control word shared by every channel of the same PLL. Each channel takes its own hold flag from that word through a per-instance mask. The channel runs only when both flags are clear. Starting and stopping happen on source clock edges. A stop always lets the current period finish, so the output is left low and no short pulse is produced. An active output reports whether the divider is currently running.

Top module: `pll_chan_div`

## Requirements
- R1: While the reset is asserted, and in the first cycle after it is released with the channel not yet enabled, `div_clk` and `running` are both 0.
- R2: When idle, the channel starts on the first rising edge at which `chan_dis` is 0 and the hold flag is clear. From that edge, `running` is 1 and a period starts at its first cycle. Otherwise the channel stays idle with `div_clk` low.
- R3: While running, the period in source cycles is the divide field multiplied by the instance parameter `FIXED_DIV`.
- R4: A divide field of 0 is used as the all-ones value of the field (15 for a 4-bit field, 255 for an 8-bit field) before the fixed post-divider is applied.
- R5: Within each period of D cycles, `div_clk` is high for the first floor(D/2) cycles and low for the rest, so an odd D gives one more low cycle than high. For D = 1, `div_clk` stays low.
- R6: A change of the divide field affects only the periods that start after the current period has finished.
- R7: When the enable condition goes away, the running period finishes. `running` then falls and `div_clk` stays low with no edges until the channel starts again.
- R8: The hold flag is the bit of `pll_word` selected by the one-hot parameter `HOLD_MASK`. All other bits of `pll_word` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_field | input | DIV_W | Programmed divide value (0 selects the maximum) |
| chan_dis | input | 1 | Local channel disable flag |
| pll_word | input | WORD_W | Shared PLL control word holding the per-channel hold flags |
| div_clk | output | 1 | Registered divided clock, low whenever stopped |
| running | output | 1 | High while the divider is counting |

## Verification
The bench builds two instances side by side. The first uses a 4-bit divide field, a fixed post-divider of 3 and a hold flag at bit 9, so the zero-field maximum (period 45) and odd products are reached in a few dozen cycles. The second uses the full 8-bit field, no post-divider and a hold flag at bit 0, which reaches the period of 1 (permanently low output) and the 255-cycle maximum. Because the two hold flags sit in different bits of the shared word, one setting of that word can hold one channel while the other keeps running. This exposes any mask or bit-select error.

// File: rtl/pll_chan_div_pkg.sv
package pll_chan_div_pkg;

  // Counter width able to hold (2**div_w - 1) * fixed_div.
  function automatic int cnt_width(input int div_w, input int fixed_div);
    return div_w + $clog2(fixed_div + 1);
  endfunction

endpackage

// File: rtl/pll_chan_div_gate.sv
module pll_chan_div_gate #(
  parameter int          WORD_W    = 32,
  parameter logic [31:0] HOLD_MASK = 32'h0000_0001
) (
  input  logic              chan_dis_i,
  input  logic [WORD_W-1:0] pll_word_i,
  output logic              run_o
);
  localparam logic [WORD_W-1:0] MASK_W = WORD_W'(HOLD_MASK);

  logic hold;

  always_comb begin
    hold  = |(pll_word_i & MASK_W);
    run_o = !chan_dis_i && !hold;
  end
endmodule

// File: rtl/pll_chan_div_sel.sv
module pll_chan_div_sel #(
  parameter int DIV_W     = 8,
  parameter int FIXED_DIV = 1,
  parameter int CNT_W     = 9
) (
  input  logic [DIV_W-1:0] field_i,
  output logic [CNT_W-1:0] period_o
);
  logic [DIV_W-1:0] field_eff;

  always_comb begin
    field_eff = (field_i == '0) ? {DIV_W{1'b1}} : field_i;
    period_o  = CNT_W'(field_eff) * CNT_W'(FIXED_DIV);
  end
endmodule

// File: rtl/pll_chan_div_cnt.sv
module pll_chan_div_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             clk_o,
  output logic             act_o
);
  logic             act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] per_q, per_n;
  logic             clk_q, clk_n;
  logic             last, upd;

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    per_n = per_q;
    last  = (cnt_q == per_q - 1'b1);
    upd   = act_q || run_i;
    if (!act_q) begin
      if (run_i) begin
        act_n = 1'b1;
        cnt_n = '0;
        per_n = period_i;
      end
    end else if (last) begin
      cnt_n = '0;
      if (run_i) per_n = period_i;
      else       act_n = 1'b0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
    clk_n = act_n && (cnt_n < (per_n >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      per_q <= '0;
      clk_q <= 1'b0;
    end else if (upd) begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      per_q <= per_n;
      clk_q <= clk_n;
    end
  end

  assign clk_o = clk_q;
  assign act_o = act_q;

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < per_q)); // R3
  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (per_q != '0)); // R4
  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && cnt_q != '0) |-> $stable(per_q)); // R6
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(cnt_q) == $past(per_q) - 1'b1)); // R7
endmodule

// File: rtl/pll_chan_div.sv
module pll_chan_div
  import pll_chan_div_pkg::*;
#(
  parameter int          DIV_W     = 8,
  parameter int          FIXED_DIV = 1,
  parameter int          WORD_W    = 32,
  parameter logic [31:0] HOLD_MASK = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_field,
  input  logic              chan_dis,
  input  logic [WORD_W-1:0] pll_word,
  output logic              div_clk,
  output logic              running
);
  localparam int CNT_W = cnt_width(DIV_W, FIXED_DIV);

  logic             run;
  logic [CNT_W-1:0] period;

  pll_chan_div_gate #(.WORD_W(WORD_W), .HOLD_MASK(HOLD_MASK)) u_gate (
    .chan_dis_i (chan_dis),
    .pll_word_i (pll_word),
    .run_o      (run)
  );

  pll_chan_div_sel #(.DIV_W(DIV_W), .FIXED_DIV(FIXED_DIV), .CNT_W(CNT_W)) u_sel (
    .field_i  (div_field),
    .period_o (period)
  );

  pll_chan_div_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .period_i (period),
    .clk_o    (div_clk),
    .act_o    (running)
  );

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !div_clk); // R7
  AST_NO_START_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && (chan_dis || |(pll_word & WORD_W'(HOLD_MASK)))) |=> !running); // R2
endmodule

// File: tb/pll_chan_div_bench.sv
module pll_chan_div_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [7:0]  div8 = 8'd0;
  logic        dis = 1'b1;
  logic [31:0] word = 32'h0;
  logic        clk_a, run_a, clk_b, run_b;
  string       phase = "R1";
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Instance A: 4-bit field, post-divider 3, hold flag at bit 9
  pll_chan_div #(.DIV_W(4), .FIXED_DIV(3), .WORD_W(32), .HOLD_MASK(32'h0000_0200)) u_pll_chan_div (
    .clk(clk), .rst_n(rst_n), .div_field(div8[3:0]), .chan_dis(dis),
    .pll_word(word), .div_clk(clk_a), .running(run_a));

  // Instance B: 8-bit field, no post-divider, hold flag at bit 0
  pll_chan_div #(.DIV_W(8), .FIXED_DIV(1), .WORD_W(32), .HOLD_MASK(32'h0000_0001)) u_pll_chan_div_b (
    .clk(clk), .rst_n(rst_n), .div_field(div8), .chan_dis(dis),
    .pll_word(word), .div_clk(clk_b), .running(run_b));

  // Behavioural reference, one slot per instance
  int m_act [2];
  int m_pos [2];
  int m_per [2];

  function automatic int want_period(int i);
    int f;
    if (i == 0) begin
      f = (div8[3:0] == 0) ? 15 : int'(div8[3:0]);
      return f * 3;
    end
    f = (div8 == 0) ? 255 : int'(div8);
    return f;
  endfunction

  function automatic bit want_run(int i);
    logic [31:0] m;
    m = (i == 0) ? 32'h0000_0200 : 32'h0000_0001;
    return !dis && ((word & m) == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_act[i] = 0; m_pos[i] = 0; m_per[i] = 0;
      end else if (m_act[i] == 0) begin
        if (want_run(i)) begin
          m_act[i] = 1; m_pos[i] = 0; m_per[i] = want_period(i);
        end
      end else if (m_pos[i] == m_per[i] - 1) begin
        m_pos[i] = 0;
        if (want_run(i)) m_per[i] = want_period(i);
        else m_act[i] = 0;
      end else begin
        m_pos[i] = m_pos[i] + 1;
      end
    end
  end

  task automatic compare();
    logic ec, ea, ac, aa;
    for (int i = 0; i < 2; i++) begin
      ea = (m_act[i] != 0);
      ec = ea && (m_pos[i] < m_per[i] / 2);
      ac = (i == 0) ? clk_a : clk_b;
      aa = (i == 0) ? run_a : run_b;
      vectors++;
      if (ac !== ec || aa !== ea) begin
        miscompares++;
        $display("FAIL %s inst%0d t=%0t div_clk=%b running=%b expected div_clk=%b running=%b",
                 phase, i, $time, ac, aa, ec, ea);
      end
    end
  endtask

  task automatic run_cycles(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    phase = "R1";             // R1: reset state
    run_cycles(3);
    rst_n = 1'b1;
    run_cycles(2);
    phase = "R2";             // R2: disabled, then held, then enabled
    run_cycles(4);
    dis = 1'b0; word = 32'h0000_0201;
    run_cycles(6);
    word = 32'h0; div8 = 8'd4;
    run_cycles(40);
    phase = "R8";             // R8: unrelated word bits ignored
    word = 32'hFFFF_FDFE;
    run_cycles(60);
    phase = "R5";             // R5: odd periods and period 1
    div8 = 8'd5;
    run_cycles(60);
    div8 = 8'd1;
    run_cycles(24);
    phase = "R6";             // R6: change in mid period
    div8 = 8'd6;
    run_cycles(20);
    div8 = 8'd2;
    run_cycles(50);
    phase = "R4";             // R4: zero field gives the maximum
    div8 = 8'd0;
    run_cycles(560);
    phase = "R7";             // R7: stop completes the period
    run_cycles(7);
    dis = 1'b1;
    run_cycles(300);
    dis = 1'b0; word = 32'h0000_0200;
    run_cycles(40);
    word = 32'h0000_0001; div8 = 8'd3;
    run_cycles(60);
    phase = "R3";             // R3: period is field times post-divider
    word = 32'h0; div8 = 8'd7;
    run_cycles(100);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule